// File: doc/BRIEF.md
# Receive Packet Buffer with Per-Frame Alignment

This block sits between a receive MAC byte stream and a 32-bit host read port. Frame bytes arriving from the MAC are stored in a data buffer, and when the last byte of a frame arrives a status word is pushed into a separate status queue. The status word holds the frame's true byte length and an error flag.

The host reads the data one DWORD at a time. For each frame, a programmable number of zero bytes (0 to 31) is inserted ahead of the first frame byte. Zero filler words can be appended so that every frame occupies a whole number of host bursts. Several frames can be drained in one continuous stream, and offset and padding apply to each frame separately.

Both queues report their occupancy. A read from an empty status queue, or a data read when no complete frame is waiting, sets a sticky error interrupt. Only a soft reset clears it.

Top module: `rx_align_buf`

## Requirements
- R1: After reset, `data_bytes_o` and `stat_used_o` are 0, `rx_err_irq_o` is low, and `data_o` and `stat_o` read 0.
- R2: Frame bytes are packed little-endian in arrival order. With offset 0, the first byte of a frame appears in `data_o[7:0]` of the first word read for that frame.
- R3: When the last byte of a frame is accepted, one status entry is queued and `stat_used_o` increments. A status read returns the length in bytes in bits [15:0], the OR of `mac_err_i` over the frame's bytes in bit 16, and zeros in bits [31:17].
- R4: `data_bytes_o` equals the number of frame bytes written and not yet delivered to the host. Offset and pad bytes are not counted.
- R5: `cfg_offset_i` (0..31) places that many zero bytes before the first frame byte in the host stream.
- R6: The offset and burst setting are sampled on the first data read of a frame. Changing them during the frame has no effect until the next frame.
- R7: `cfg_burst_i` selects the burst length: 0 = 1 word, 1 = 4 words, 2 = 8 words, 3 = 16 words. Zero filler words follow the frame until the frame's word count is a multiple of the burst length.
- R8: Bytes after a frame's last byte within its final word read as zero. The next frame's data starts on a fresh word, with its own offset and padding applied.
- R9: A status read while `stat_used_o` is 0, or a data read while no complete frame is pending, sets `rx_err_irq_o`. The interrupt stays set until a soft reset.
- R10: `soft_rst_i` empties both queues, clears `rx_err_irq_o` and the host read state, and returns the outputs to their reset values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| soft_rst_i | input | 1 | Synchronous soft reset of all state |
| mac_valid_i | input | 1 | Frame byte valid |
| mac_byte_i | input | 8 | Frame byte |
| mac_last_i | input | 1 | Byte is the last of its frame |
| mac_err_i | input | 1 | Receive error seen on this byte |
| cfg_offset_i | input | 5 | Leading zero bytes per frame |
| cfg_burst_i | input | 2 | Burst length select |
| data_rd_i | input | 1 | Host DWORD read strobe |
| data_o | output | 32 | Read DWORD, valid the cycle after the strobe |
| stat_rd_i | input | 1 | Host status read strobe |
| stat_o | output | 32 | Status word, valid the cycle after the strobe |
| data_bytes_o | output | AW+1 | Stored frame bytes not yet read |
| stat_used_o | output | SAW+1 | Queued status entries |
| rx_err_irq_o | output | 1 | Sticky underrun interrupt |

## Verification
A wrong read-pointer advance or lost last-byte marker shows up on the very next word as a shifted or duplicated byte. It also breaks every frame after it. A wrong word-position or latched-offset register shows up in the first word of a frame as misplaced zeros. A padding count off by one either leaves a filler word that the next frame's first read returns, or swallows the next frame's first word. Both are visible within one burst. Occupancy errors appear directly on `data_bytes_o` or `stat_used_o` the cycle after the write or read that caused them.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned POS_W  = 16;

  // burst select -> (words per burst - 1)
  function automatic logic [POS_W-1:0] burst_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16'd0;
      2'd1:    return 16'd3;
      2'd2:    return 16'd7;
      default: return 16'd15;
    endcase
  endfunction
endpackage

// File: rtl/rxb_byte_store.sv
module rxb_byte_store #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [7:0]   wr_byte_i,
  input  logic         wr_last_i,
  input  logic [2:0]   adv_i,
  output logic [7:0]   peek_byte_o [4],
  output logic         peek_last_o [4],
  output logic [AW:0]  used_o
);
  logic [8:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   used_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= {wr_last_i, wr_byte_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      used_q   <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      used_q   <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      rd_ptr_q <= rd_ptr_q + AW'(adv_i);
      used_q   <= used_q + (AW+1)'(wr_i) - (AW+1)'(adv_i);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_peek
    logic [AW-1:0] addr;
    assign addr           = rd_ptr_q + AW'(g);
    assign peek_byte_o[g] = mem_q[addr][7:0];
    assign peek_last_o[g] = mem_q[addr][8];
  end

  assign used_o = used_q;

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |-> (used_q < (AW+1)'(DEPTH)));
endmodule

// File: rtl/rxb_stat_fifo.sv
module rxb_stat_fifo #(
  parameter int unsigned W     = 17,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] pop_data_o,
  output logic [AW:0]  count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_pop;

  assign do_pop = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; pop_data_o <= '0;
    end else if (clr_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; pop_data_o <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (do_pop) rp_q <= rp_q + 1'b1;
      if (pop_i)  pop_data_o <= do_pop ? mem_q[rp_q] : '0;
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(do_pop);
    end
  end

  assign count_o = cnt_q;

  p_stat_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |-> (cnt_q < (AW+1)'(DEPTH)));
endmodule

// File: rtl/rxb_host_rd.sv
module rxb_host_rd
  import rxb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic [4:0]        offset_i,
  input  logic [1:0]        burst_i,
  input  logic              frame_avail_i,
  input  logic [7:0]        peek_byte_i [4],
  input  logic              peek_last_i [4],
  output logic [2:0]        adv_o,
  output logic              frame_done_o,
  output logic              underrun_o,
  output logic [WORD_W-1:0] data_o
);
  logic             in_frame_q, ended_q;
  logic [4:0]       off_q;
  logic [POS_W-1:0] mask_q, wpos_q;

  logic [4:0]       off_e;
  logic [POS_W-1:0] mask_e, wpos_e, wpos_n;
  logic             run_end, done, accept;
  logic [2:0]       k;
  logic [WORD_W-1:0] word;
  logic [POS_W+1:0] v;

  always_comb begin
    off_e   = in_frame_q ? off_q   : offset_i;
    mask_e  = in_frame_q ? mask_q  : burst_mask(burst_i);
    wpos_e  = in_frame_q ? wpos_q  : '0;
    run_end = in_frame_q ? ended_q : 1'b0;
    k       = '0;
    word    = '0;
    v       = '0;
    for (int i = 0; i < 4; i++) begin
      v = {wpos_e, 2'(i)};
      if (!run_end && v >= (POS_W+2)'(off_e)) begin
        word[8*i +: 8] = peek_byte_i[k[1:0]];
        if (peek_last_i[k[1:0]]) run_end = 1'b1;
        k = k + 3'd1;
      end
    end
    wpos_n = wpos_e + 1'b1;
    done   = run_end && ((wpos_n & mask_e) == '0);
  end

  assign accept       = rd_i && (in_frame_q || frame_avail_i);
  assign adv_o        = accept ? k : 3'd0;
  assign frame_done_o = accept && done;
  assign underrun_o   = rd_i && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0; ended_q <= 1'b0; off_q <= '0;
      mask_q <= '0; wpos_q <= '0; data_o <= '0;
    end else if (clr_i) begin
      in_frame_q <= 1'b0; ended_q <= 1'b0; off_q <= '0;
      mask_q <= '0; wpos_q <= '0; data_o <= '0;
    end else if (rd_i) begin
      data_o <= accept ? word : '0;
      if (accept) begin
        in_frame_q <= !done;
        off_q      <= off_e;
        mask_q     <= mask_e;
        wpos_q     <= wpos_n;
        ended_q    <= run_end;
      end
    end
  end

  // a frame in progress keeps its sampled offset
  p_offset_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && !clr_i) |=> $stable(off_q) || !in_frame_q || $past(!in_frame_q));
endmodule

// File: rtl/rx_align_buf.sv
module rx_align_buf
  import rxb_pkg::*;
#(
  parameter int unsigned DATA_DEPTH = 1024,
  parameter int unsigned STAT_DEPTH = 16,
  localparam int unsigned AW  = $clog2(DATA_DEPTH),
  localparam int unsigned SAW = $clog2(STAT_DEPTH),
  localparam int unsigned FW  = SAW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              mac_valid_i,
  input  logic [7:0]        mac_byte_i,
  input  logic              mac_last_i,
  input  logic              mac_err_i,
  input  logic [4:0]        cfg_offset_i,
  input  logic [1:0]        cfg_burst_i,
  input  logic              data_rd_i,
  output logic [WORD_W-1:0] data_o,
  input  logic              stat_rd_i,
  output logic [WORD_W-1:0] stat_o,
  output logic [AW:0]       data_bytes_o,
  output logic [SAW:0]      stat_used_o,
  output logic              rx_err_irq_o
);
  logic [7:0]       peek_byte [4];
  logic             peek_last [4];
  logic [2:0]       adv;
  logic             frame_done, data_under, stat_under, push;
  logic [POS_W-1:0] len_q;
  logic             err_q, irq_q;
  logic [FW-1:0]    frames_q;
  logic [16:0]      stat_raw;

  assign push = mac_valid_i && mac_last_i && !soft_rst_i;

  rxb_byte_store #(.DEPTH(DATA_DEPTH)) u_store (
    .clk_i, .rst_ni, .clr_i(soft_rst_i),
    .wr_i(mac_valid_i && !soft_rst_i), .wr_byte_i(mac_byte_i), .wr_last_i(mac_last_i),
    .adv_i(adv), .peek_byte_o(peek_byte), .peek_last_o(peek_last), .used_o(data_bytes_o)
  );

  rxb_stat_fifo #(.W(17), .DEPTH(STAT_DEPTH)) u_stat (
    .clk_i, .rst_ni, .clr_i(soft_rst_i),
    .push_i(push), .push_data_i({err_q | mac_err_i, len_q + 1'b1}),
    .pop_i(stat_rd_i), .pop_data_o(stat_raw), .count_o(stat_used_o)
  );

  rxb_host_rd u_rd (
    .clk_i, .rst_ni, .clr_i(soft_rst_i),
    .rd_i(data_rd_i), .offset_i(cfg_offset_i), .burst_i(cfg_burst_i),
    .frame_avail_i(frames_q != '0), .peek_byte_i(peek_byte), .peek_last_i(peek_last),
    .adv_o(adv), .frame_done_o(frame_done), .underrun_o(data_under), .data_o(data_o)
  );

  assign stat_o     = {15'd0, stat_raw};
  assign stat_under = stat_rd_i && (stat_used_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0; err_q <= 1'b0; frames_q <= '0; irq_q <= 1'b0;
    end else if (soft_rst_i) begin
      len_q <= '0; err_q <= 1'b0; frames_q <= '0; irq_q <= 1'b0;
    end else begin
      if (mac_valid_i) begin
        len_q <= mac_last_i ? '0 : len_q + 1'b1;
        err_q <= mac_last_i ? 1'b0 : (err_q | mac_err_i);
      end
      frames_q <= frames_q + FW'(push) - FW'(frame_done);
      if (data_under || stat_under) irq_q <= 1'b1;
    end
  end

  assign rx_err_irq_o = irq_q;

  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_irq_o && !soft_rst_i) |=> rx_err_irq_o);
  p_stat_empty_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && stat_used_o == '0 && !soft_rst_i) |=> rx_err_irq_o);
  p_soft_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!rx_err_irq_o && stat_used_o == '0 && data_bytes_o == '0));
endmodule

// File: tb/rx_align_buf_tb_top.sv
module rx_align_buf_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, soft_rst = 1'b0;
  logic mac_valid = 0, mac_last = 0, mac_err = 0;
  logic [7:0] mac_byte = '0;
  logic [4:0] cfg_off = '0;
  logic [1:0] cfg_burst = '0;
  logic data_rd = 0, stat_rd = 0;
  logic [31:0] data_o, stat_o;
  logic [10:0] data_bytes;
  logic [4:0] stat_used;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  rx_align_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .mac_valid_i(mac_valid), .mac_byte_i(mac_byte), .mac_last_i(mac_last), .mac_err_i(mac_err),
    .cfg_offset_i(cfg_off), .cfg_burst_i(cfg_burst),
    .data_rd_i(data_rd), .data_o(data_o), .stat_rd_i(stat_rd), .stat_o(stat_o),
    .data_bytes_o(data_bytes), .stat_used_o(stat_used), .rx_err_irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed, input bit err);
    for (int i = 0; i < len; i++) begin
      mac_valid = 1; mac_byte = seed + 8'(i); mac_last = (i == len - 1);
      mac_err = err && (i == len / 2);
      @(negedge clk);
    end
    mac_valid = 0; mac_last = 0; mac_err = 0;
  endtask

  task automatic rd_word(output logic [31:0] w);
    data_rd = 1; @(negedge clk); data_rd = 0; w = data_o;
  endtask

  task automatic rd_stat(output logic [31:0] s);
    stat_rd = 1; @(negedge clk); stat_rd = 0; s = stat_o;
  endtask

  function automatic logic [31:0] exp_word(int len, int off, logic [7:0] seed, int w);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int v = w * 4 + i;
      if (v >= off && v - off < len) r[8*i +: 8] = seed + 8'(v - off);
    end
    return r;
  endfunction

  function automatic int total_words(int len, int off, int bsel);
    int bl = (bsel == 0) ? 1 : (bsel == 1) ? 4 : (bsel == 2) ? 8 : 16;
    int t = (off + len + 3) / 4;
    return ((t + bl - 1) / bl) * bl;
  endfunction

  task automatic drain(input string req, input int len, input int off, input int bsel, input logic [7:0] seed);
    logic [31:0] w;
    for (int k = 0; k < total_words(len, off, bsel); k++) begin
      rd_word(w);
      chk(req, w, exp_word(len, off, seed, k));
    end
  endtask

  // {len, offset, burst select, error}
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{5, 0, 0, 0}, '{8, 3, 1, 1}, '{1, 31, 0, 0},
    '{13, 7, 2, 0}, '{20, 2, 3, 1}, '{4, 0, 1, 0}
  };

  initial begin
    #5000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, s;
    @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1
    chk("R1 bytes", 32'(data_bytes), 0);
    chk("R1 stat", 32'(stat_used), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 data", data_o, 0);

    for (int n = 0; n < NV; n++) begin
      logic [7:0] seed = 8'(8'h10 * n + 8'h01);
      send_frame(VEC[n][0], seed, VEC[n][3] != 0);
      chk("R4 bytes stored", 32'(data_bytes), 32'(VEC[n][0]));
      chk("R3 stat count", 32'(stat_used), 1);
      rd_stat(s);
      chk("R3 status word", s, {15'd0, 1'(VEC[n][3]), 16'(VEC[n][0])});
      cfg_off = 5'(VEC[n][1]); cfg_burst = 2'(VEC[n][2]);
      drain("R2 R5 R7 frame data", VEC[n][0], VEC[n][1], VEC[n][2], seed);
      chk("R4 bytes drained", 32'(data_bytes), 0);
    end

    // R6: offset change mid-frame ignored
    cfg_off = 5'd2; cfg_burst = 2'd1;
    send_frame(10, 8'h40, 0);
    rd_word(w); chk("R6 first", w, exp_word(10, 2, 8'h40, 0));
    cfg_off = 5'd9; cfg_burst = 2'd0;
    for (int k = 1; k < 4; k++) begin
      rd_word(w); chk("R6 held", w, exp_word(10, 2, 8'h40, k));
    end
    rd_stat(s);

    // R8: two frames read as one stream, each with own offset/pad
    cfg_off = 5'd1; cfg_burst = 2'd1;
    send_frame(6, 8'h80, 0);
    send_frame(3, 8'hA0, 0);
    chk("R3 two queued", 32'(stat_used), 2);
    drain("R8 frame a", 6, 1, 1, 8'h80);
    cfg_off = 5'd5; cfg_burst = 2'd0;
    drain("R8 frame b", 3, 5, 0, 8'hA0);
    chk("R9 no irq yet", 32'(irq), 0);

    // R9: data over-read
    rd_word(w);
    chk("R9 data underrun irq", 32'(irq), 1);
    rd_stat(s); rd_stat(s);
    chk("R9 irq sticky", 32'(irq), 1);
    // R10
    send_frame(3, 8'h01, 0);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk("R10 irq cleared", 32'(irq), 0);
    chk("R10 stat empty", 32'(stat_used), 0);
    chk("R10 bytes empty", 32'(data_bytes), 0);
    // R9: status over-read
    rd_stat(s);
    chk("R9 stat underrun irq", 32'(irq), 1);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    // resume after soft reset
    cfg_off = 5'd0; cfg_burst = 2'd0;
    send_frame(4, 8'hC0, 0);
    drain("R10 resume", 4, 0, 0, 8'hC0);
    chk("R10 resume irq", 32'(irq), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule